// File: doc/BRIEF.md
# UART Receiver Status Flag Unit

This block keeps the error and status flags of a UART-style receiver. The receive datapath reports what it sees as single-cycle event pulses: a parity error, a break character, a low sample at the start of the start-bit search, a false start, an idle character and a completed frame. The block turns these pulses into held flags for parity error, framing error, receive-full, break and reception-in-progress. It also produces an error interrupt request and presents the second status byte. Software clears the flags by reading, and never by writing.

Each clearable flag is cleared in two steps. First its status register is read while the flag is set, which arms the clear. A later read of the data register then clears the flag. A new event for the flag that arrives between the two reads cancels the pending clear. The break flag has one extra rule: once it has been cleared, it cannot set again until the receive line has been seen high. This stops a line held low from raising the flag again and again. The reset input is asynchronous and active-low, and the block releases it synchronously through a short synchronizer.

Top module: `uart_rx_flag_unit`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, every flag, `err_irq`, `ninth_bit` and `stat2_byte` read 0.
- R2: A pulse on `ev_parity_err` sets `flag_parity` on the next edge. It clears only on a `rd_data` pulse that comes in a later cycle than a `rd_stat1` pulse made while the flag was set. A `rd_data` pulse with no arming read before it leaves the flag set.
- R3: `err_irq` is high exactly when `flag_parity` and `perr_irq_en` are both high. The break, framing and busy flags never drive it.
- R4: A pulse on `ev_break` sets `flag_frame_err` and `flag_rx_full` on the next edge. When `nine_bit_mode` is high it also forces `ninth_bit` to 0.
- R5: `flag_break` is armed for clearing only by a `rd_stat2` pulse made while it is set, and never by `rd_stat1`. A later `rd_data` pulse then clears it.
- R6: After `flag_break` is cleared, a further `ev_break` leaves it at 0 until `rx_line_high` has been high for at least one cycle. The first `ev_break` after that sets it again. Framing-error and receive-full are still set by every break.
- R7: `ev_start_low` sets `flag_rx_busy`. `ev_false_start` or `ev_idle` clears it. If a start-low pulse and a clearing pulse come in the same cycle, the flag ends up set.
- R8: `stat2_byte` carries `flag_break` at bit 1 and `flag_rx_busy` at bit 0, with bits 7 to 2 always 0.
- R9: An event for a flag that comes after its arming status read and before the data read cancels the pending clear. The following data read leaves the flag set, and a new status read is needed before it can be cleared.
- R10: If a set event and a completing data read fall in the same cycle, the flag stays set and its pending clear is dropped.
- R11: A `wr_stat2` pulse, whatever the value on `wr_data`, changes no flag and does not change `stat2_byte`.
- R12: `ev_frame_done` sets `flag_rx_full`. In `nine_bit_mode` it also loads `ninth_bit` from `ninth_bit_in`, unless a break comes in the same cycle, in which case the break wins. `flag_frame_err` and `flag_rx_full` are armed by `rd_stat1` and cleared by a later `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perr_irq_en | input | 1 | Enables the parity error interrupt |
| nine_bit_mode | input | 1 | Frames carry a ninth data bit |
| rx_line_high | input | 1 | Receive line observed at logic one this cycle |
| ev_parity_err | input | 1 | Parity error detected in the current frame |
| ev_break | input | 1 | Break character detected |
| ev_start_low | input | 1 | Low sample in the first slot of the start-bit search |
| ev_false_start | input | 1 | Start bit rejected as false |
| ev_idle | input | 1 | Idle character detected |
| ev_frame_done | input | 1 | Frame received into the data register |
| ninth_bit_in | input | 1 | Ninth data bit of the completed frame |
| rd_stat1 | input | 1 | Read strobe of status register 1 |
| rd_stat2 | input | 1 | Read strobe of status register 2 |
| rd_data | input | 1 | Read strobe of the data register |
| wr_stat2 | input | 1 | Write strobe of status register 2 |
| wr_data | input | 8 | Write data bus |
| flag_parity | output | 1 | Parity error flag |
| flag_frame_err | output | 1 | Framing error flag |
| flag_rx_full | output | 1 | Receive data register full flag |
| flag_break | output | 1 | Break flag |
| flag_rx_busy | output | 1 | Reception in progress flag |
| ninth_bit | output | 1 | Stored ninth data bit |
| err_irq | output | 1 | Error interrupt request |
| stat2_byte | output | 8 | Read value of status register 2 |

## Verification
Two things can land on the same flag in one cycle: a set event and the data read that would finish its clear. The directed part of the bench forces this on purpose. It arms the parity flag, then pulses the parity event and the data read on the same edge. The flag must stay set, and a later data read on its own must still not clear it. The random part draws events and read strobes every cycle with sizeable probabilities, so collisions like this occur often. A bench reference model built from the requirements predicts every output on every cycle.

// File: rtl/uart_rx_flag_pkg.sv
package uart_rx_flag_pkg;
  // Clearable flags managed by the two-step clear cells
  localparam int unsigned NUM_CLR_FLAGS = 4;
  localparam int unsigned IDX_PARITY    = 0;
  localparam int unsigned IDX_FRAME     = 1;
  localparam int unsigned IDX_FULL      = 2;
  localparam int unsigned IDX_BREAK     = 3;
  // Bit positions inside status byte 2
  localparam int unsigned S2_BUSY_BIT   = 0;
  localparam int unsigned S2_BREAK_BIT  = 1;
endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_clr_flag.sv
module uart_rx_clr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic arm_rd_i,
  input  logic data_rd_i,
  output logic flag_o,
  output logic clr_done_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic complete;

  always_comb begin
    complete   = flag_q & armed_q & data_rd_i;
    // a set event always wins and drops any pending clear
    flag_d     = set_i | (flag_q & ~complete);
    armed_d    = ~set_i & flag_q & ~complete & (armed_q | arm_rd_i);
    clr_done_o = complete & ~set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_rx_brk_gate.sv
module uart_rx_brk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic break_ev_i,
  input  logic line_high_i,
  input  logic flag_cleared_i,
  output logic break_set_o
);
  logic blocked_q, blocked_d;
  logic blk_en;

  always_comb begin
    blk_en    = flag_cleared_i | line_high_i;
    // a clear in the same cycle as a high line still blocks
    blocked_d = flag_cleared_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blocked_q <= 1'b0;
    else if (blk_en) blocked_q <= blocked_d;
  end

  assign break_set_o = break_ev_i & ~blocked_q;
endmodule

// File: rtl/uart_rx_busy_track.sv
module uart_rx_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_low_i,
  input  logic false_start_i,
  input  logic idle_i,
  input  logic nine_mode_i,
  input  logic frame_done_i,
  input  logic break_i,
  input  logic ninth_in_i,
  output logic busy_o,
  output logic ninth_o
);
  logic busy_q, busy_d, busy_en;
  logic ninth_q, ninth_d, ninth_en;

  always_comb begin
    busy_en  = start_low_i | false_start_i | idle_i;
    busy_d   = start_low_i;
    ninth_en = nine_mode_i & (break_i | frame_done_i);
    ninth_d  = ~break_i & ninth_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ninth_q <= 1'b0;
    end else begin
      if (busy_en)  busy_q  <= busy_d;
      if (ninth_en) ninth_q <= ninth_d;
    end
  end

  assign busy_o  = busy_q;
  assign ninth_o = ninth_q;
endmodule

// File: rtl/uart_rx_flag_unit.sv
module uart_rx_flag_unit
  import uart_rx_flag_pkg::*;
#(
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perr_irq_en,
  input  logic              nine_bit_mode,
  input  logic              rx_line_high,
  input  logic              ev_parity_err,
  input  logic              ev_break,
  input  logic              ev_start_low,
  input  logic              ev_false_start,
  input  logic              ev_idle,
  input  logic              ev_frame_done,
  input  logic              ninth_bit_in,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  input  logic              rd_data,
  input  logic              wr_stat2,
  input  logic [STAT_W-1:0] wr_data,
  output logic              flag_parity,
  output logic              flag_frame_err,
  output logic              flag_rx_full,
  output logic              flag_break,
  output logic              flag_rx_busy,
  output logic              ninth_bit,
  output logic              err_irq,
  output logic [STAT_W-1:0] stat2_byte
);
  localparam int unsigned PAD_W = STAT_W - 2;

  logic                     rst_sync_n;
  logic [NUM_CLR_FLAGS-1:0] set_ev, arm_rd, flag_q, clr_done;
  logic                     break_set;
  logic                     unused_in;

  // status register 2 has no writable bits
  assign unused_in = ^{wr_stat2, wr_data, clr_done[IDX_FULL:IDX_PARITY]};

  uart_rx_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  uart_rx_brk_gate brk_gate_i (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .break_ev_i     (ev_break),
    .line_high_i    (rx_line_high),
    .flag_cleared_i (clr_done[IDX_BREAK]),
    .break_set_o    (break_set)
  );

  always_comb begin
    set_ev             = '0;
    arm_rd             = '0;
    set_ev[IDX_PARITY] = ev_parity_err;
    set_ev[IDX_FRAME]  = ev_break;
    set_ev[IDX_FULL]   = ev_break | ev_frame_done;
    set_ev[IDX_BREAK]  = break_set;
    arm_rd[IDX_PARITY] = rd_stat1;
    arm_rd[IDX_FRAME]  = rd_stat1;
    arm_rd[IDX_FULL]   = rd_stat1;
    arm_rd[IDX_BREAK]  = rd_stat2;
  end

  for (genvar g = 0; g < NUM_CLR_FLAGS; g++) begin : g_flag
    uart_rx_clr_flag flag_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .set_i      (set_ev[g]),
      .arm_rd_i   (arm_rd[g]),
      .data_rd_i  (rd_data),
      .flag_o     (flag_q[g]),
      .clr_done_o (clr_done[g])
    );
  end

  uart_rx_busy_track busy_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_low_i   (ev_start_low),
    .false_start_i (ev_false_start),
    .idle_i        (ev_idle),
    .nine_mode_i   (nine_bit_mode),
    .frame_done_i  (ev_frame_done),
    .break_i       (ev_break),
    .ninth_in_i    (ninth_bit_in),
    .busy_o        (flag_rx_busy),
    .ninth_o       (ninth_bit)
  );

  assign flag_parity    = flag_q[IDX_PARITY];
  assign flag_frame_err = flag_q[IDX_FRAME];
  assign flag_rx_full   = flag_q[IDX_FULL];
  assign flag_break     = flag_q[IDX_BREAK];
  assign err_irq        = flag_parity & perr_irq_en;

  always_comb begin
    stat2_byte               = {{PAD_W{1'b0}}, 2'b00};
    stat2_byte[S2_BREAK_BIT] = flag_break;
    stat2_byte[S2_BUSY_BIT]  = flag_rx_busy;
  end
endmodule

// File: rtl/uart_rx_flag_unit_chk.sv
module uart_rx_flag_unit_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              perr_irq_en,
  input logic              nine_bit_mode,
  input logic              ev_parity_err,
  input logic              ev_break,
  input logic              ev_start_low,
  input logic              ev_false_start,
  input logic              ev_idle,
  input logic              rd_data,
  input logic              flag_parity,
  input logic              flag_frame_err,
  input logic              flag_rx_full,
  input logic              flag_break,
  input logic              flag_rx_busy,
  input logic              ninth_bit,
  input logic              err_irq,
  input logic [STAT_W-1:0] stat2_byte
);
  a_r8_stat2_upper_zero: assert property (@(posedge clk) disable iff (!rst_ok_n)
    stat2_byte[STAT_W-1:2] == '0);

  a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_ok_n)
    err_irq |-> flag_parity);

  a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !perr_irq_en |-> !err_irq);

  a_r10_parity_set_wins: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_parity_err |=> flag_parity);

  a_r2_parity_clear_by_data_read: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $fell(flag_parity) |-> $past(rd_data));

  a_r5_break_clear_by_data_read: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $fell(flag_break) |-> $past(rd_data));

  a_r4_break_side_flags: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_break |=> (flag_frame_err && flag_rx_full));

  a_r4_break_ninth_clear: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_break && nine_bit_mode) |=> !ninth_bit);

  a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_start_low |=> flag_rx_busy);

  a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((ev_false_start || ev_idle) && !ev_start_low) |=> !flag_rx_busy);
endmodule

bind uart_rx_flag_unit uart_rx_flag_unit_chk #(.STAT_W(STAT_W)) chk_i (
  .clk            (clk),
  .rst_ok_n       (rst_sync_n),
  .perr_irq_en    (perr_irq_en),
  .nine_bit_mode  (nine_bit_mode),
  .ev_parity_err  (ev_parity_err),
  .ev_break       (ev_break),
  .ev_start_low   (ev_start_low),
  .ev_false_start (ev_false_start),
  .ev_idle        (ev_idle),
  .rd_data        (rd_data),
  .flag_parity    (flag_parity),
  .flag_frame_err (flag_frame_err),
  .flag_rx_full   (flag_rx_full),
  .flag_break     (flag_break),
  .flag_rx_busy   (flag_rx_busy),
  .ninth_bit      (ninth_bit),
  .err_irq        (err_irq),
  .stat2_byte     (stat2_byte)
);

// File: tb/uart_rx_flag_unit_tb_top.sv
`timescale 1ns/1ps
module uart_rx_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic perr_irq_en, nine_bit_mode, rx_line_high;
  logic ev_parity_err, ev_break, ev_start_low, ev_false_start, ev_idle, ev_frame_done;
  logic ninth_bit_in, rd_stat1, rd_stat2, rd_data, wr_stat2;
  logic [7:0] wr_data;
  logic flag_parity, flag_frame_err, flag_rx_full, flag_break, flag_rx_busy;
  logic ninth_bit, err_irq;
  logic [7:0] stat2_byte;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  logic m_pe, m_fe, m_rf, m_bk, a_pe, a_fe, a_rf, a_bk, m_blk, m_busy, m_n9;

  always #4 clk = ~clk;

  uart_rx_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .perr_irq_en(perr_irq_en), .nine_bit_mode(nine_bit_mode),
    .rx_line_high(rx_line_high), .ev_parity_err(ev_parity_err), .ev_break(ev_break),
    .ev_start_low(ev_start_low), .ev_false_start(ev_false_start), .ev_idle(ev_idle),
    .ev_frame_done(ev_frame_done), .ninth_bit_in(ninth_bit_in), .rd_stat1(rd_stat1),
    .rd_stat2(rd_stat2), .rd_data(rd_data), .wr_stat2(wr_stat2), .wr_data(wr_data),
    .flag_parity(flag_parity), .flag_frame_err(flag_frame_err), .flag_rx_full(flag_rx_full),
    .flag_break(flag_break), .flag_rx_busy(flag_rx_busy), .ninth_bit(ninth_bit),
    .err_irq(err_irq), .stat2_byte(stat2_byte)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] flag_next(logic set, logic arm, logic drd, logic f, logic a);
    logic done, nf, na;
    done = f & a & drd;
    nf   = set | (f & ~done);
    na   = ~set & f & ~done & (a | arm);
    return {nf, na, done & ~set};
  endfunction

  task automatic model_reset();
    {m_pe, m_fe, m_rf, m_bk, a_pe, a_fe, a_rf, a_bk, m_blk, m_busy, m_n9} = '0;
  endtask

  task automatic model_step();
    logic [2:0] r;
    logic bk_set;
    bk_set = ev_break & ~m_blk;
    r = flag_next(ev_parity_err, rd_stat1, rd_data, m_pe, a_pe); {m_pe, a_pe} = r[2:1];
    r = flag_next(ev_break, rd_stat1, rd_data, m_fe, a_fe);      {m_fe, a_fe} = r[2:1];
    r = flag_next(ev_break | ev_frame_done, rd_stat1, rd_data, m_rf, a_rf); {m_rf, a_rf} = r[2:1];
    r = flag_next(bk_set, rd_stat2, rd_data, m_bk, a_bk);        {m_bk, a_bk} = r[2:1];
    if (r[0]) m_blk = 1'b1;
    else if (rx_line_high) m_blk = 1'b0;
    if (ev_start_low) m_busy = 1'b1;
    else if (ev_false_start | ev_idle) m_busy = 1'b0;
    if (nine_bit_mode & ev_break) m_n9 = 1'b0;
    else if (nine_bit_mode & ev_frame_done) m_n9 = ninth_bit_in;
  endtask

  task automatic cmp_all();
    chk("R2 parity flag", {7'd0, flag_parity}, {7'd0, m_pe});
    chk("R12 frame err flag", {7'd0, flag_frame_err}, {7'd0, m_fe});
    chk("R12 rx full flag", {7'd0, flag_rx_full}, {7'd0, m_rf});
    chk("R5 break flag", {7'd0, flag_break}, {7'd0, m_bk});
    chk("R7 busy flag", {7'd0, flag_rx_busy}, {7'd0, m_busy});
    chk("R12 ninth bit", {7'd0, ninth_bit}, {7'd0, m_n9});
    chk("R3 err irq", {7'd0, err_irq}, {7'd0, m_pe & perr_irq_en});
    chk("R8 stat2 byte", stat2_byte, {6'd0, m_bk, m_busy});
  endtask

  task automatic clr_pulses();
    {ev_parity_err, ev_break, ev_start_low, ev_false_start, ev_idle, ev_frame_done} = '0;
    {rd_stat1, rd_stat2, rd_data, wr_stat2} = '0;
    wr_data = 8'h00;
  endtask

  task automatic step();
    model_step();
    @(posedge clk); #2;
    cmp_all();
    clr_pulses();
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    {perr_irq_en, nine_bit_mode, rx_line_high, ninth_bit_in} = '0;
    clr_pulses();
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while held
    chk("R1 flags in reset", {flag_parity, flag_frame_err, flag_rx_full, flag_break,
        flag_rx_busy, ninth_bit, err_irq, 1'b0}, 8'h00);
    chk("R1 stat2 in reset", stat2_byte, 8'h00);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 stat2 after release", stat2_byte, 8'h00);

    // R2 / R3: parity set, irq gating, data read alone does not clear
    ev_parity_err = 1; step();
    chk("R2 parity set", {7'd0, flag_parity}, 8'h01);
    chk("R3 irq masked", {7'd0, err_irq}, 8'h00);
    perr_irq_en = 1; #1;
    chk("R3 irq enabled", {7'd0, err_irq}, 8'h01);
    rd_data = 1; step();
    chk("R2 lone data read keeps flag", {7'd0, flag_parity}, 8'h01);
    rd_stat1 = 1; step();
    rd_data = 1; step();
    chk("R2 two-step clear", {7'd0, flag_parity}, 8'h00);
    chk("R3 irq drops", {7'd0, err_irq}, 8'h00);

    // R9: event between status read and data read cancels the clear
    ev_parity_err = 1; step();
    rd_stat1 = 1; step();
    ev_parity_err = 1; step();
    rd_data = 1; step();
    chk("R9 cancelled clear", {7'd0, flag_parity}, 8'h01);
    rd_data = 1; step();
    chk("R9 still needs status read", {7'd0, flag_parity}, 8'h01);
    rd_stat1 = 1; step();
    rd_data = 1; step();
    chk("R9 cleared after rearm", {7'd0, flag_parity}, 8'h00);

    // R10: set and completing read in the same cycle
    ev_parity_err = 1; step();
    rd_stat1 = 1; step();
    ev_parity_err = 1; rd_data = 1; step();
    chk("R10 set wins", {7'd0, flag_parity}, 8'h01);
    rd_data = 1; step();
    chk("R10 pending clear dropped", {7'd0, flag_parity}, 8'h01);
    rd_stat1 = 1; step();
    rd_data = 1; step();

    // R12 / R4: frame with ninth bit, then break
    nine_bit_mode = 1; ninth_bit_in = 1; ev_frame_done = 1; step();
    chk("R12 ninth bit loaded", {7'd0, ninth_bit}, 8'h01);
    chk("R12 rx full set", {7'd0, flag_rx_full}, 8'h01);
    ev_break = 1; step();
    chk("R4 break side flags", {6'd0, flag_frame_err, flag_rx_full}, 8'h03);
    chk("R4 ninth bit cleared", {7'd0, ninth_bit}, 8'h00);
    chk("R8 stat2 break bit", stat2_byte, 8'h02);

    // R5: stat1 read does not arm break
    rd_stat1 = 1; step();
    rd_data = 1; step();
    chk("R12 fe and rf cleared", {6'd0, flag_frame_err, flag_rx_full}, 8'h00);
    chk("R5 break kept by stat1 read", {7'd0, flag_break}, 8'h01);
    rd_stat2 = 1; step();
    rd_data = 1; step();
    chk("R5 break cleared", {7'd0, flag_break}, 8'h00);

    // R6: rearm only after line seen high
    ev_break = 1; step();
    chk("R6 break blocked", {7'd0, flag_break}, 8'h00);
    chk("R6 fe still set", {7'd0, flag_frame_err}, 8'h01);
    rx_line_high = 1; step();
    rx_line_high = 0;
    ev_break = 1; step();
    chk("R6 break after ones", {7'd0, flag_break}, 8'h01);

    // R7: busy flag
    ev_start_low = 1; step();
    chk("R8 stat2 both bits", stat2_byte, 8'h03);
    ev_false_start = 1; step();
    chk("R7 false start clears", {7'd0, flag_rx_busy}, 8'h00);
    ev_start_low = 1; step();
    ev_idle = 1; step();
    chk("R7 idle clears", {7'd0, flag_rx_busy}, 8'h00);
    ev_start_low = 1; ev_idle = 1; step();
    chk("R7 start wins", {7'd0, flag_rx_busy}, 8'h01);

    // R11: writes to status register 2 ignored
    wr_stat2 = 1; wr_data = 8'h00; step();
    chk("R11 write zero ignored", stat2_byte, 8'h03);
    wr_stat2 = 1; wr_data = 8'hFF; step();
    chk("R11 write ones ignored", stat2_byte, 8'h03);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      ev_parity_err  = ($urandom % 8) == 0;
      ev_break       = ($urandom % 10) == 0;
      ev_start_low   = ($urandom % 6) == 0;
      ev_false_start = ($urandom % 8) == 0;
      ev_idle        = ($urandom % 8) == 0;
      ev_frame_done  = ($urandom % 6) == 0;
      ninth_bit_in   = $urandom % 2;
      rd_stat1       = ($urandom % 3) == 0;
      rd_stat2       = ($urandom % 3) == 0;
      rd_data        = ($urandom % 3) == 0;
      wr_stat2       = ($urandom % 8) == 0;
      wr_data        = 8'($urandom);
      rx_line_high   = ($urandom % 5) == 0;
      if ((i % 64) == 0) begin
        nine_bit_mode = $urandom % 2;
        perr_irq_en   = $urandom % 2;
      end
      step();
    end

    finished = 1;
    report();
  end
endmodule